// File: doc/BRIEF.md
# Clock-Mode Power Management Controller

This block derives the clock enables for a small processor core and for its on-chip timers from a single oscillator clock. A shared prescaler produces one tick every N oscillator cycles. The divide ratio N comes from a 2-bit selection that software writes. A selection of 00 gives full speed (N = 4), 01 gives the first reduced rate (N = 64) and 10 gives the second reduced rate (N = 1024). The code 11 is reserved and runs at full speed. A new selection takes effect only when the prescaler rolls over, so an enable pulse is never cut short or spaced irregularly.

On top of the divided tick sit three operating states. In run, both the CPU enable and the timer enable follow the tick. A one-cycle idle strobe moves the block to idle: the CPU enable stops, and the timer enable keeps ticking at the selected rate so that a timer can raise a wake-up. A one-cycle stop strobe moves the block to stop: both enables stop and the prescaler is held at zero. A wake request returns the block from idle or from stop to run without any reset, so the core resumes where it halted. The wake request is an interrupt or alarm that has already been masked by its enable. A status output reports the current state and the active divide selection.

Top module: `clkpm_ctrl`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock) is asserted, the state is run, the active selection is 00 and both enables are low. After release, the first enables are high in the fourth clock cycle, where the release cycle counts as the first.
- R2: The active selection code sets the enable period: 00 gives 4 cycles, 01 gives 64 cycles, 10 gives 1024 cycles and 11 gives 4 cycles. In run, both enables pulse together at that period.
- R3: A write on `mode_wr` stores `mode_sel` as a pending selection. The pending selection becomes active at the next prescaler rollover, so a write made in the middle of a period leaves that period's length unchanged.
- R4: `idle_set` in run moves the block to idle on the next cycle. In idle, `cpu_ce` stays low and `tmr_ce` keeps pulsing at the active period.
- R5: `stop_set` in run moves the block to stop on the next cycle, and it wins over `idle_set` in the same cycle. In stop, both enables stay low.
- R6: `wake_req` seen in idle or stop returns the block to run on the next cycle. After a wake from stop, the first enable pair comes exactly 4 cycles after the wake cycle at full speed, because the prescaler restarts from zero.
- R7: `wake_req` in run has no effect. `idle_set` and `stop_set` are ignored unless the state is run.
- R8: `pm_state` encodes run as 00, idle as 01 and stop as 10. `pm_div` shows the active selection code, and it changes only at a rollover.
- R9: Each enable is high for exactly one cycle per period, and `cpu_ce` is never high without `tmr_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the divide selection |
| mode_sel | input | 2 | Divide selection code written on `mode_wr` |
| idle_set | input | 1 | One-cycle request to enter idle |
| stop_set | input | 1 | One-cycle request to enter stop |
| wake_req | input | 1 | Enabled interrupt or alarm wake request |
| cpu_ce | output | 1 | CPU clock enable |
| tmr_ce | output | 1 | Timer and peripheral clock enable |
| pm_state | output | 2 | Current state: 00 run, 01 idle, 10 stop |
| pm_div | output | 2 | Active divide selection code |

## Verification
The divide function is driven through a vector table that walks all four selection codes, including the reserved one, and returns to codes it has already used. The table tells a true period change apart from a stale or mis-decoded ratio. It also shows that 11 falls back to full speed and does not wrap into a slow rate. A write placed in the middle of a 1024-cycle period separates deferred adoption from an immediate ratio change, which would leave a runt period. Pulse counts taken over fixed windows in idle and stop separate gating of the CPU enable alone from gating of both enables. The exact delay from a wake out of stop to the first enable shows whether the prescaler restarts from zero.

// File: rtl/clkpm_pkg.sv
// Shared types for the clock-mode power management controller.
package clkpm_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_IDLE = 2'b01,
        PM_STOP = 2'b10
    } pm_state_e;
endpackage

// File: rtl/clkpm_prescale.sv
// Shared prescaler. It produces a one-cycle tick every N input clocks, where
// N is set by the active divide selection. The pending selection becomes
// active only on the rollover edge. Assumes all three ratios are at least 2.
// While halt is high the counter is held at zero and no tick is produced.
module clkpm_prescale #(
    parameter int DIV_FULL = 4,
    parameter int DIV_LOW1 = 64,
    parameter int DIV_LOW2 = 1024,
    localparam int DIV_MAX = (DIV_LOW2 > DIV_LOW1) ?
                             ((DIV_LOW2 > DIV_FULL) ? DIV_LOW2 : DIV_FULL) :
                             ((DIV_LOW1 > DIV_FULL) ? DIV_LOW1 : DIV_FULL),
    localparam int CW = $clog2(DIV_MAX)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    output logic       tick,
    output logic [1:0] act_sel
);
    logic [1:0]    pend_sel;
    logic [1:0]    pend_nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Map a selection code to its divide ratio; the reserved code runs at full speed.
    function automatic int ratio_of(input logic [1:0] s);
        case (s)
            2'b01:   ratio_of = DIV_LOW1;
            2'b10:   ratio_of = DIV_LOW2;
            default: ratio_of = DIV_FULL;
        endcase
    endfunction

    // Terminal count for the active ratio, and the selection a rollover would adopt.
    always_comb begin
        last     = CW'(ratio_of(act_sel) - 1);
        pend_nxt = cfg_wr ? cfg_sel : pend_sel;
        tick     = !halt && (cnt == last);
    end

    // Capture the software selection on each write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_sel <= 2'b00;
        else if (cfg_wr) pend_sel <= cfg_sel;
    end

    // Count, roll over, and adopt the pending selection only at the rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_sel <= 2'b00;
        end else if (halt) begin
            cnt     <= '0;
        end else if (tick) begin
            cnt     <= '0;
            act_sel <= pend_nxt;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    // R3 / R8: the active selection moves only on a rollover edge.
    a_r3_sel_at_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |-> $past(tick));
    // R2: the counter never passes the terminal count of the active ratio.
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= last) || $past(tick) || $past(halt));
    // R6: a halted prescaler restarts from zero.
    a_r6_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt) |-> (cnt == '0));
endmodule

// File: rtl/clkpm_fsm.sv
// Run / idle / stop state machine. Set strobes are honoured only in run, with
// stop taking priority over idle. A wake request leaves idle or stop on the
// next edge. Assumes the strobes are already synchronous to clk.
module clkpm_fsm
    import clkpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_set,
    input  logic      stop_set,
    input  logic      wake_req,
    output pm_state_e state
);
    // Next-state selection and state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PM_RUN;
        end else begin
            case (state)
                PM_RUN: begin
                    if (stop_set)      state <= PM_STOP;
                    else if (idle_set) state <= PM_IDLE;
                end
                PM_IDLE, PM_STOP: begin
                    if (wake_req)      state <= PM_RUN;
                end
                default:               state <= PM_RUN;
            endcase
        end
    end

    // R6: a wake request out of a low-power state gives run on the next cycle.
    a_r6_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PM_RUN && wake_req) |=> (state == PM_RUN));
    // R5: stop has priority over idle when both are requested in run.
    a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && stop_set) |=> (state == PM_STOP));
    // R7: without a wake, stop is held whatever set strobes arrive.
    a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STOP && !wake_req) |=> (state == PM_STOP));
endmodule

// File: rtl/clkpm_gate.sv
// Enable gating. The divided tick reaches the timer enable in run and idle,
// and the CPU enable in run only. Purely combinational.
module clkpm_gate
    import clkpm_pkg::*;
(
    input  pm_state_e state,
    input  logic      tick,
    output logic      cpu_ce,
    output logic      tmr_ce
);
    // Qualify the tick by the current state.
    always_comb begin
        cpu_ce = tick && (state == PM_RUN);
        tmr_ce = tick && (state != PM_STOP);
    end
endmodule

// File: rtl/clkpm_ctrl.sv
// Top of the clock-mode power management controller. It ties the prescaler,
// the state machine and the gating together and drives the status outputs.
// Assumes every input is synchronous to clk.
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int DIV_FULL = 4,
    parameter int DIV_LOW1 = 64,
    parameter int DIV_LOW2 = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_sel,
    input  logic       idle_set,
    input  logic       stop_set,
    input  logic       wake_req,
    output logic       cpu_ce,
    output logic       tmr_ce,
    output logic [1:0] pm_state,
    output logic [1:0] pm_div
);
    pm_state_e  state;
    logic       tick;
    logic [1:0] act_sel;

    clkpm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_set (idle_set),
        .stop_set (stop_set),
        .wake_req (wake_req),
        .state    (state)
    );

    clkpm_prescale #(
        .DIV_FULL (DIV_FULL),
        .DIV_LOW1 (DIV_LOW1),
        .DIV_LOW2 (DIV_LOW2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (state == PM_STOP),
        .cfg_wr  (mode_wr),
        .cfg_sel (mode_sel),
        .tick    (tick),
        .act_sel (act_sel)
    );

    clkpm_gate u_gate (
        .state  (state),
        .tick   (tick),
        .cpu_ce (cpu_ce),
        .tmr_ce (tmr_ce)
    );

    // Status outputs.
    always_comb begin
        pm_state = state;
        pm_div   = act_sel;
    end

    // R5: no enable leaves the block in stop.
    a_r5_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_STOP) |-> (!tmr_ce && !cpu_ce));
    // R4: the CPU enable stays low in idle.
    a_r4_idle_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_IDLE) |-> !cpu_ce);
    // R9: the CPU enable implies the timer enable.
    a_r9_cpu_in_tmr: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |-> tmr_ce);
    // R9: the timer enable is a single-cycle pulse.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ce |=> !tmr_ce);
endmodule

// File: tb/clkpm_ctrl_tb.sv
module clkpm_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       idle_set = 1'b0;
    logic       stop_set = 1'b0;
    logic       wake_req = 1'b0;
    logic       cpu_ce, tmr_ce;
    logic [1:0] pm_state, pm_div;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int NV = 6;
    localparam logic [1:0] V_SEL [0:NV-1] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00};
    localparam int         V_PER [0:NV-1] = '{4, 64, 1024, 4, 64, 4};

    always #2 clk = ~clk;

    clkpm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .idle_set(idle_set), .stop_set(stop_set), .wake_req(wake_req),
        .cpu_ce(cpu_ce), .tmr_ce(tmr_ce), .pm_state(pm_state), .pm_div(pm_div)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedges until tmr_ce is seen high.
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tmr_ce && n < 4000);
    endtask

    task automatic write_sel(input logic [1:0] s);
        mode_wr = 1'b1; mode_sel = s;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n, nc, nt;
        repeat (3) @(negedge clk);
        // R1 / R8: reset state
        chk(pm_state == 2'b00, "R1 reset state", pm_state, 0);
        chk(pm_div == 2'b00, "R8 reset div", pm_div, 0);
        chk(!cpu_ce && !tmr_ce, "R1 enables low in reset", cpu_ce + tmr_ce, 0);
        rst_n = 1'b1;
        wait_tick(n);
        chk(n == 3, "R1 first enable cycle", n, 3);
        chk(cpu_ce == 1'b1, "R2 cpu_ce with tmr_ce", cpu_ce, 1);

        // R2 / R8 / R9: vector table of selection codes
        for (int i = 0; i < NV; i++) begin
            write_sel(V_SEL[i]);
            wait_tick(n);
            wait_tick(n);
            chk(n == V_PER[i], "R2 period", n, V_PER[i]);
            chk(cpu_ce == 1'b1, "R2 cpu_ce in run", cpu_ce, 1);
            chk(pm_div == V_SEL[i], "R8 active div", pm_div, V_SEL[i]);
            @(negedge clk);
            chk(!tmr_ce && !cpu_ce, "R9 one-cycle pulse", tmr_ce + cpu_ce, 0);
            wait_tick(n);
        end

        // R3: a write in the middle of a long period does not shorten it
        write_sel(2'b10);
        wait_tick(n);
        wait_tick(n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin mode_wr = 1'b1; mode_sel = 2'b00; end
            if (n == 2) mode_wr = 1'b0;
            if (n == 500) chk(pm_div == 2'b10, "R3 div held mid period", pm_div, 2);
        end while (!tmr_ce && n < 4000);
        chk(n == 1024, "R3 no runt period", n, 1024);
        wait_tick(n);
        chk(n == 4, "R3 new ratio after rollover", n, 4);
        chk(pm_div == 2'b00, "R8 div after rollover", pm_div, 0);

        // R4: idle gates the CPU only
        idle_set = 1'b1;
        @(negedge clk);
        idle_set = 1'b0;
        chk(pm_state == 2'b01, "R4 enter idle", pm_state, 1);
        nc = 0; nt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            nc += int'(cpu_ce);
            nt += int'(tmr_ce);
        end
        chk(nc == 0, "R4 cpu_ce off in idle", nc, 0);
        chk(nt == 10, "R4 timer pulses in idle", nt, 10);

        // R7: stop request ignored in idle
        stop_set = 1'b1;
        @(negedge clk);
        stop_set = 1'b0;
        chk(pm_state == 2'b01, "R7 stop ignored in idle", pm_state, 1);

        // R6: wake from idle
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk(pm_state == 2'b00, "R6 wake from idle", pm_state, 0);
        wait_tick(n);
        chk(cpu_ce == 1'b1, "R6 cpu_ce after idle wake", cpu_ce, 1);

        // R7: wake in run has no effect
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk(pm_state == 2'b00, "R7 wake in run", pm_state, 0);
        wait_tick(n);
        wait_tick(n);
        chk(n == 4, "R7 period kept after wake in run", n, 4);

        // R5: stop wins over idle, all enables off
        stop_set = 1'b1; idle_set = 1'b1;
        @(negedge clk);
        stop_set = 1'b0; idle_set = 1'b0;
        chk(pm_state == 2'b10, "R5 stop over idle", pm_state, 2);
        nt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            nt += int'(tmr_ce) + int'(cpu_ce);
        end
        chk(nt == 0, "R5 no enables in stop", nt, 0);
        idle_set = 1'b1;
        @(negedge clk);
        idle_set = 1'b0;
        chk(pm_state == 2'b10, "R7 idle ignored in stop", pm_state, 2);

        // R6: wake from stop restarts the prescaler
        wake_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            wake_req = 1'b0;
            if (n == 1) chk(pm_state == 2'b00, "R6 wake from stop", pm_state, 0);
        end while (!tmr_ce && n < 4000);
        chk(n == 4, "R6 first enable after stop", n, 4);
        chk(cpu_ce == 1'b1, "R6 cpu_ce after stop", cpu_ce, 1);

        // R1: reset in the middle of operation
        write_sel(2'b10);
        wait_tick(n);
        idle_set = 1'b1;
        @(negedge clk);
        idle_set = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(pm_state == 2'b00, "R1 reset clears idle", pm_state, 0);
        chk(pm_div == 2'b00, "R1 reset selects full speed", pm_div, 0);
        rst_n = 1'b1;
        wait_tick(n);
        chk(n == 3, "R1 first enable after mid reset", n, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule